// File: doc/BRIEF.md
# Stall Protection Timer

This block supervises a running motor for stall. While the run command is high and the speed loop reports that it is out of lock, a leaky accumulator counts up on a slow internal tick. When the count reaches a threshold derived from a programmable interval setting, a registered trip flag is set. The trip flag is meant to switch off the low-side drivers. It stays set until the run command is dropped. Regaining lock does not clear it.

The accumulator does not restart from zero. While the motor runs in lock, it keeps its value. It drains only while the motor is stopped, and it drains much faster than it fills. A short stop therefore leaves a residual count, and the following stall trips sooner. A strap input keeps the trip from ever being raised while the timer still runs.

The threshold is `interval_set * UNIT_TICKS` ticks. A tick occurs once every `TICK_DIV` clock cycles. Each tick while stopped removes `DRAIN_STEP` from the count.

Top module: `stall_guard`

## Requirements
- R1: A synchronous active-high `rst` drives `timer_o` to 0 and `trip_o` to 0 at the next rising edge. The tick divider restarts, so the first tick falls on the `TICK_DIV`-th edge after the last reset edge, and the ticks repeat every `TICK_DIV` edges after that.
- R2: On a tick edge with `run_cmd`=1 and `unlocked`=1, `timer_o` becomes the smaller of `timer_o`+1 and the threshold (`interval_set*UNIT_TICKS`). Edges without a tick leave it unchanged.
- R3: With `run_cmd`=1 and `unlocked`=0, `timer_o` keeps its value on every edge.
- R4: On a charging tick edge that makes `timer_o` equal to the threshold, `trip_o` rises at that same edge when `guard_off`=0. It then stays 1 while `run_cmd`=1 and `guard_off`=0, whatever `unlocked` does.
- R5: The first edge with `run_cmd`=0 clears `trip_o`. Regaining lock while running never clears it.
- R6: On a tick edge with `run_cmd`=0, `timer_o` drops by `DRAIN_STEP` and is clamped at 0. Edges without a tick leave it unchanged.
- R7: While `guard_off`=1, `trip_o` is 0 at the following edge and never rises. `timer_o` still charges, holds and drains as in R2, R3 and R6.
- R8: A stop shorter than the full drain leaves residual count. The next trip then needs only as many charging ticks as the threshold minus that residual.
- R9: When the threshold is at or below `timer_o`, including a setting of 0, the next charging tick loads the threshold into `timer_o` and trips (subject to R7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_cmd | input | 1 | 1 = motor commanded to run, 0 = stop |
| unlocked | input | 1 | 1 = speed loop out of lock |
| interval_set | input | SET_W | Trip interval in units of UNIT_TICKS ticks |
| guard_off | input | 1 | 1 = protection disabled (trip never raised) |
| trip_o | output | 1 | Registered stall trip, low-side drive off when 1 |
| timer_o | output | CNT_W | Registered accumulator value |

## Verification
Two events can land on the same edge: a charging tick that makes the count reach the threshold, which raises the trip, and a change in the threshold or the strap. A lowered interval setting or a strap toggled right at the final tick is one such case. A stop that begins at the tick edge is another, because the drain and the trip clear then compete with the charge. The bench provokes these collisions with directed threshold drops and with random toggling of all four inputs, aligned to tick edges. A cycle model built from the requirements judges every edge by comparing `trip_o` and `timer_o`.

// File: rtl/stall_guard_pkg.sv
package stall_guard_pkg;
  typedef enum logic [1:0] {
    ACC_DRAIN  = 2'd0,
    ACC_CHARGE = 2'd1,
    ACC_HOLD   = 2'd2
  } acc_mode_e;
endpackage

// File: rtl/sg_tick_gen.sv
module sg_tick_gen #(
  parameter int TICK_DIV = 16
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] pre_q;

  assign tick = (pre_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)       pre_q <= '0;
    else if (tick) pre_q <= '0;
    else           pre_q <= pre_q + 1'b1;
  end

  // R1: the divider never passes its last value
  a_r1_div_range: assert property (@(posedge clk) disable iff (rst) pre_q <= LAST);
endmodule

// File: rtl/sg_mode_dec.sv
module sg_mode_dec
  import stall_guard_pkg::*;
(
  input  logic      run_cmd,
  input  logic      unlocked,
  output acc_mode_e mode
);
  always_comb begin
    if (!run_cmd)     mode = ACC_DRAIN;
    else if (unlocked) mode = ACC_CHARGE;
    else              mode = ACC_HOLD;
  end
endmodule

// File: rtl/sg_accum.sv
module sg_accum
  import stall_guard_pkg::*;
#(
  parameter int SET_W      = 8,
  parameter int UNIT_TICKS = 22,
  parameter int DRAIN_STEP = 22,
  parameter int CNT_W      = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  acc_mode_e        mode,
  input  logic [SET_W-1:0] interval_set,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] thr,
  output logic             hit
);
  localparam logic [CNT_W-1:0] UNIT_C  = CNT_W'(UNIT_TICKS);
  localparam logic [CNT_W-1:0] DRAIN_C = CNT_W'(DRAIN_STEP);

  logic [CNT_W-1:0] count_n;

  assign thr = CNT_W'(interval_set) * UNIT_C;

  always_comb begin
    count_n = count;
    hit     = 1'b0;
    if (tick) begin
      unique case (mode)
        ACC_CHARGE: begin
          count_n = (count >= thr) ? thr : count + 1'b1;
          hit     = (count_n == thr);
        end
        ACC_DRAIN:  count_n = (count < DRAIN_C) ? '0 : count - DRAIN_C;
        default:    count_n = count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count_n;
  end

  // R3: locked while running keeps the count
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (mode == ACC_HOLD) |=> (count == $past(count)));
  // R6: stop never raises the count
  a_r6_drain_down: assert property (@(posedge clk) disable iff (rst)
    (mode == ACC_DRAIN) |=> (count <= $past(count)));
  // R2: no change without a tick
  a_r2_tick_only: assert property (@(posedge clk) disable iff (rst)
    !tick |=> (count == $past(count)));
endmodule

// File: rtl/sg_trip_latch.sv
module sg_trip_latch
  import stall_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  acc_mode_e mode,
  input  logic      hit,
  input  logic      guard_off,
  output logic      trip
);
  always_ff @(posedge clk) begin
    if (rst) trip <= 1'b0;
    else     trip <= (mode != ACC_DRAIN) && !guard_off && (trip || hit);
  end

  // R5: a stop clears the trip at the next edge
  a_r5_stop_clears: assert property (@(posedge clk) disable iff (rst)
    (mode == ACC_DRAIN) |=> !trip);
  // R7: strap keeps the trip low
  a_r7_strap_low: assert property (@(posedge clk) disable iff (rst)
    guard_off |=> !trip);
endmodule

// File: rtl/stall_guard.sv
module stall_guard
  import stall_guard_pkg::*;
#(
  parameter int SET_W      = 8,
  parameter int UNIT_TICKS = 22,
  parameter int DRAIN_STEP = 22,
  parameter int TICK_DIV   = 16,
  localparam int THR_MAX   = ((1 << SET_W) - 1) * UNIT_TICKS,
  localparam int CNT_W     = $clog2(THR_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_cmd,
  input  logic             unlocked,
  input  logic [SET_W-1:0] interval_set,
  input  logic             guard_off,
  output logic             trip_o,
  output logic [CNT_W-1:0] timer_o
);
  logic             tick;
  acc_mode_e        mode;
  logic [CNT_W-1:0] thr;
  logic             hit;

  sg_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  sg_mode_dec u_mode (
    .run_cmd(run_cmd), .unlocked(unlocked), .mode(mode)
  );

  sg_accum #(
    .SET_W(SET_W), .UNIT_TICKS(UNIT_TICKS), .DRAIN_STEP(DRAIN_STEP), .CNT_W(CNT_W)
  ) u_acc (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .interval_set(interval_set),
    .count(timer_o), .thr(thr), .hit(hit)
  );

  sg_trip_latch u_trip (
    .clk(clk), .rst(rst), .mode(mode), .hit(hit), .guard_off(guard_off), .trip(trip_o)
  );

  // R1: reset empties the timer and clears the trip
  a_r1_reset: assert property (@(posedge clk) rst |=> (timer_o == '0) && !trip_o);
  // R4: a new trip only appears with the count at the threshold
  a_r4_trip_at_thr: assert property (@(posedge clk) disable iff (rst)
    $rose(trip_o) |-> (timer_o == $past(thr)));
endmodule

// File: tb/stall_guard_bench.sv
module stall_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SET_W = 4;
  localparam int UNIT_TICKS = 5;
  localparam int DRAIN_STEP = 3;
  localparam int TICK_DIV = 3;
  localparam int THR_MAX = ((1 << SET_W) - 1) * UNIT_TICKS;
  localparam int CNT_W = $clog2(THR_MAX + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_cmd = 1'b0, unlocked = 1'b0, guard_off = 1'b0;
  logic [SET_W-1:0] interval_set = '0;
  logic trip_o;
  logic [CNT_W-1:0] timer_o;

  int tests = 0, fails = 0;
  int m_pre = 0, m_cnt = 0;
  bit m_trip = 0;
  string phase_tag = "";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stall_guard #(.SET_W(SET_W), .UNIT_TICKS(UNIT_TICKS), .DRAIN_STEP(DRAIN_STEP),
                .TICK_DIV(TICK_DIV)) u_stall_guard (
    .clk(clk), .rst(rst), .run_cmd(run_cmd), .unlocked(unlocked),
    .interval_set(interval_set), .guard_off(guard_off),
    .trip_o(trip_o), .timer_o(timer_o));

  function automatic string timer_tag();
    if (phase_tag != "") return phase_tag;
    if (rst) return "R1";
    if (!run_cmd) return "R6";
    return unlocked ? "R2" : "R3";
  endfunction

  function automatic string trip_tag();
    if (phase_tag != "") return phase_tag;
    if (rst) return "R1";
    if (guard_off) return "R7";
    return run_cmd ? "R4" : "R5";
  endfunction

  task automatic check(input string tag, input int act, input int exp, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one clock: model advanced from inputs seen at the edge, compared after it
  task automatic cycle();
    string t1, t2;
    int thr;
    bit tick, hit;
    @(posedge clk);
    t1 = timer_tag(); t2 = trip_tag();
    if (rst) begin
      m_pre = 0; m_cnt = 0; m_trip = 0;
    end else begin
      tick = (m_pre == TICK_DIV - 1);
      m_pre = tick ? 0 : m_pre + 1;
      thr = int'(interval_set) * UNIT_TICKS;
      hit = 0;
      if (run_cmd) begin
        if (unlocked && tick) begin
          m_cnt = (m_cnt >= thr) ? thr : m_cnt + 1;
          hit = (m_cnt == thr);
        end
      end else if (tick) begin
        m_cnt = (m_cnt < DRAIN_STEP) ? 0 : m_cnt - DRAIN_STEP;
      end
      m_trip = run_cmd && !guard_off && (m_trip || hit);
    end
    @(negedge clk);
    check(t1, int'(timer_o), m_cnt, "timer_o");
    check(t2, int'(trip_o), int'(m_trip), "trip_o");
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd4711));
    @(negedge clk);
    // R1: reset state
    rst = 1'b1; run_cycles(2);
    check("R1", int'(timer_o), 0, "timer after reset");
    check("R1", int'(trip_o), 0, "trip after reset");
    rst = 1'b0;

    // R2 R4: plain stall with set 4 -> threshold 20
    interval_set = 4'd4; run_cmd = 1; unlocked = 1;
    run_cycles(20 * TICK_DIV + 2);
    check("R4", int'(trip_o), 1, "trip after full stall");
    check("R2", int'(timer_o), 20, "timer clamped at threshold");

    // R5: lock regained keeps the trip, stop clears it
    unlocked = 0; run_cycles(10);
    check("R5", int'(trip_o), 1, "trip kept while locked");
    run_cmd = 0; run_cycles(1);
    check("R5", int'(trip_o), 0, "trip cleared by stop");

    // R6: full drain clamps at zero
    run_cycles(12 * TICK_DIV);
    check("R6", int'(timer_o), 0, "drained to zero");

    // R3: partial charge then hold
    run_cmd = 1; unlocked = 1; run_cycles(7 * TICK_DIV);
    unlocked = 0; run_cycles(5 * TICK_DIV);
    check("R3", int'(timer_o), m_cnt, "held while locked");

    // R8: short stop leaves residual, next trip sooner
    phase_tag = "R8";
    unlocked = 1; run_cycles(8 * TICK_DIV);
    run_cmd = 0; run_cycles(2 * TICK_DIV);
    check("R8", int'(timer_o) > 0 ? 1 : 0, 1, "residual after short stop");
    run_cmd = 1; run_cycles((20 - int'(timer_o)) * TICK_DIV + 1);
    check("R8", int'(trip_o), 1, "early trip from residual");
    phase_tag = "";

    // R7: strap blocks trip, timer still clamps
    run_cmd = 0; run_cycles(1);
    guard_off = 1; run_cmd = 1; unlocked = 1;
    run_cycles(25 * TICK_DIV);
    check("R7", int'(trip_o), 0, "no trip with strap");
    check("R7", int'(timer_o), 20, "timer clamps with strap");
    guard_off = 0; run_cycles(TICK_DIV + 1);

    // R9: threshold lowered under the count, then setting zero
    phase_tag = "R9";
    run_cmd = 0; run_cycles(12 * TICK_DIV);
    interval_set = 4'd10; run_cmd = 1; unlocked = 1; run_cycles(30 * TICK_DIV);
    interval_set = 4'd2; run_cycles(TICK_DIV);
    check("R9", int'(timer_o), 10, "clamped to lowered threshold");
    check("R9", int'(trip_o), 1, "trip on lowered threshold");
    run_cmd = 0; run_cycles(6 * TICK_DIV);
    interval_set = 4'd0; run_cmd = 1; run_cycles(TICK_DIV);
    check("R9", int'(trip_o), 1, "setting zero trips at first tick");
    phase_tag = "";

    // random mix, collisions checked every edge by the model
    run_cmd = 0; interval_set = 4'd3;
    for (int i = 0; i < 6000; i++) begin
      rst       = ($urandom_range(0, 299) == 0);
      run_cmd   = ($urandom_range(0, 9) < 7);
      unlocked  = ($urandom_range(0, 9) < 8);
      guard_off = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 49) == 0) interval_set = SET_W'($urandom_range(0, 6));
      run_cycles($urandom_range(1, 4));
    end
    rst = 0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule